// File: doc/BRIEF.md
# Mode-Banked Multiport Register File

This block holds the architectural integer registers of a 32-bit RISC core. Software sees sixteen registers, numbered with 4-bit addresses. Some of those numbers lead to different physical storage depending on the processor mode presented on `mode_i`. The fast-interrupt mode has private copies of registers 8 through 12. Each exception mode has its own copies of registers 13 (stack pointer) and 14 (link register). The core reads three operands per cycle through combinational ports and retires up to two results per cycle through clocked write ports.

Register 15 is the program counter, and its storage lives outside this block. Reads of register 15 return the value on `pc_in`. Writes to register 15 leave the store unchanged and raise a strobe that carries the data to the fetch logic. Thirty words of flip-flop storage hold the rest. With the external counter this gives 31 physical general-purpose registers.

Top module: `banked_regfile`

## Requirements
- R1: Each of the three read ports returns, in the same cycle and with no clock edge in between, the stored 32-bit value of the physical register that its 4-bit address and the current mode select. A write in the same cycle is not forwarded, so the read returns the old value.
- R2: Each of the two write ports stores its data into the selected physical register on a rising clock edge when its enable is high. The new value is visible to reads after that edge.
- R3: Addresses 0 to 7 reach the same physical register in every mode value.
- R4: Addresses 8 to 12 reach one shared set of registers in all modes except fast-interrupt (mode 5'h11), which reaches its own five registers.
- R5: Addresses 13 and 14 reach a separate pair per bank. User (5'h10) and system (5'h1F) share one pair. Fast-interrupt (5'h11), interrupt (5'h12), supervisor (5'h13), abort (5'h17) and undefined (5'h1B) each have a pair of their own.
- R6: A mode value not listed in R4 and R5 reaches the user bank.
- R7: A read of address 15 returns `pc_in`.
- R8: An enabled write to address 15 changes no stored register. In that same cycle it drives `pc_write` high and `pc_wdata` to the write data. When no such write occurs, `pc_write` is low.
- R9: When both write ports target the same physical register in one cycle, the register takes the data of write port 1. When both target address 15, `pc_wdata` carries the port 1 data.
- R10: A synchronous active-high reset clears every stored register to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mode_i | input | 5 | Current processor mode code |
| pc_in | input | 32 | Program counter value returned for address 15 |
| rd0_addr | input | 4 | Read port 0 register number |
| rd0_data | output | 32 | Read port 0 data |
| rd1_addr | input | 4 | Read port 1 register number |
| rd1_data | output | 32 | Read port 1 data |
| rd2_addr | input | 4 | Read port 2 register number |
| rd2_data | output | 32 | Read port 2 data |
| wr0_en | input | 1 | Write port 0 enable |
| wr0_addr | input | 4 | Write port 0 register number |
| wr0_data | input | 32 | Write port 0 data |
| wr1_en | input | 1 | Write port 1 enable |
| wr1_addr | input | 4 | Write port 1 register number |
| wr1_data | input | 32 | Write port 1 data |
| pc_write | output | 1 | Strobe: a write to address 15 is happening this cycle |
| pc_wdata | output | 32 | Data for the program counter while `pc_write` is high |

## Verification
Two things can fall into the same cycle. The first is both write ports resolving to one physical register, or both addressing the program counter. The second is a read of a register that is also being written in that cycle. Random traffic forces write port 1 onto the address of port 0 in about a quarter of the cycles, and directed cases make the two ports collide on a banked register and on address 15. A reference model in the bench applies port 0 and then port 1, and the next cycle's reads are compared against it. Reads taken in the write cycle must still show the old contents.

// File: rtl/rf_pkg.sv
package rf_pkg;

    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 4;
    localparam int N_PHYS  = 30;
    localparam int PIDX_W  = $clog2(N_PHYS);
    localparam int N_RD    = 3;
    localparam int N_WR    = 2;
    localparam logic [ADDR_W-1:0] PC_NUM      = 4'd15;
    localparam logic [ADDR_W-1:0] FIRST_FAST  = 4'd8;
    localparam logic [ADDR_W-1:0] FIRST_PAIR  = 4'd13;
    localparam int FAST_BASE = 15;
    localparam int PAIR_BASE = 20;

    typedef enum logic [2:0] {
        BK_USER  = 3'd0,
        BK_FAST  = 3'd1,
        BK_IRQ   = 3'd2,
        BK_SVC   = 3'd3,
        BK_ABORT = 3'd4,
        BK_UNDEF = 3'd5
    } bank_e;

    typedef struct packed {
        logic              is_pc;
        logic [PIDX_W-1:0] idx;
    } slot_t;

    function automatic bank_e bank_of(input logic [4:0] mode);
        case (mode)
            5'h11:   return BK_FAST;
            5'h12:   return BK_IRQ;
            5'h13:   return BK_SVC;
            5'h17:   return BK_ABORT;
            5'h1B:   return BK_UNDEF;
            default: return BK_USER;
        endcase
    endfunction

    function automatic slot_t locate(input logic [ADDR_W-1:0] num, input bank_e bank);
        slot_t s;
        int    k;
        s.is_pc = 1'b0;
        k       = int'(num);
        if (num == PC_NUM) begin
            s.is_pc = 1'b1;
            k       = 0;
        end else if (num >= FIRST_PAIR) begin
            if (bank != BK_USER)
                k = PAIR_BASE + 2 * (int'(bank) - 1) + (int'(num) - int'(FIRST_PAIR));
        end else if (num >= FIRST_FAST) begin
            if (bank == BK_FAST)
                k = FAST_BASE + (int'(num) - int'(FIRST_FAST));
        end
        s.idx = PIDX_W'(k);
        return s;
    endfunction

endpackage

// File: rtl/rf_bank_map.sv
module rf_bank_map
    import rf_pkg::*;
(
    input  logic [ADDR_W-1:0] num_i,
    input  bank_e             bank_i,
    output slot_t             slot_o
);
    always_comb slot_o = locate(num_i, bank_i);
endmodule

// File: rtl/rf_store.sv
module rf_store
    import rf_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int DEPTH = N_PHYS,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       we0,
    input  logic [IW-1:0]              idx0,
    input  logic [DW-1:0]              d0,
    input  logic                       we1,
    input  logic [IW-1:0]              idx1,
    input  logic [DW-1:0]              d1,
    output logic [DEPTH-1:0][DW-1:0]   q
);
    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic hit0, hit1;
        assign hit0 = we0 && (idx0 == IW'(g));
        assign hit1 = we1 && (idx1 == IW'(g));
        always_ff @(posedge clk) begin
            if (rst)        q[g] <= '0;
            else if (hit1)  q[g] <= d1;
            else if (hit0)  q[g] <= d0;
        end
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_pkg::*;
#(
    parameter int DW    = DATA_W,
    parameter int DEPTH = N_PHYS
) (
    input  logic [ADDR_W-1:0]          num_i,
    input  bank_e                      bank_i,
    input  logic [DEPTH-1:0][DW-1:0]   store_i,
    input  logic [DW-1:0]              pc_i,
    output logic [DW-1:0]              data_o
);
    slot_t slot;

    rf_bank_map u_map (.num_i(num_i), .bank_i(bank_i), .slot_o(slot));

    always_comb begin
        if (slot.is_pc) data_o = pc_i;
        else            data_o = store_i[slot.idx];
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import rf_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        mode_i,
    input  logic [DW-1:0]     pc_in,
    input  logic [ADDR_W-1:0] rd0_addr,
    output logic [DW-1:0]     rd0_data,
    input  logic [ADDR_W-1:0] rd1_addr,
    output logic [DW-1:0]     rd1_data,
    input  logic [ADDR_W-1:0] rd2_addr,
    output logic [DW-1:0]     rd2_data,
    input  logic              wr0_en,
    input  logic [ADDR_W-1:0] wr0_addr,
    input  logic [DW-1:0]     wr0_data,
    input  logic              wr1_en,
    input  logic [ADDR_W-1:0] wr1_addr,
    input  logic [DW-1:0]     wr1_data,
    output logic              pc_write,
    output logic [DW-1:0]     pc_wdata
);
    bank_e bank;
    assign bank = bank_of(mode_i);

    logic [N_RD-1:0][ADDR_W-1:0] rnum;
    logic [N_RD-1:0][DW-1:0]     rdat;
    logic [N_WR-1:0][ADDR_W-1:0] wnum;
    logic [N_WR-1:0][DW-1:0]     wdat;
    logic [N_WR-1:0]             wen;
    slot_t [N_WR-1:0]            wslot;
    logic [N_WR-1:0]             wstore;
    logic [N_WR-1:0]             wpc;

    assign rnum = {rd2_addr, rd1_addr, rd0_addr};
    assign {rd2_data, rd1_data, rd0_data} = rdat;
    assign wnum = {wr1_addr, wr0_addr};
    assign wdat = {wr1_data, wr0_data};
    assign wen  = {wr1_en, wr0_en};

    logic [N_PHYS-1:0][DW-1:0] store;

    for (genvar w = 0; w < N_WR; w++) begin : g_wr
        rf_bank_map u_map (.num_i(wnum[w]), .bank_i(bank), .slot_o(wslot[w]));
        assign wstore[w] = wen[w] && !wslot[w].is_pc;
        assign wpc[w]    = wen[w] &&  wslot[w].is_pc;
    end

    rf_store #(.DW(DW), .DEPTH(N_PHYS)) u_store (
        .clk (clk),
        .rst (rst),
        .we0 (wstore[0]),
        .idx0(wslot[0].idx),
        .d0  (wdat[0]),
        .we1 (wstore[1]),
        .idx1(wslot[1].idx),
        .d1  (wdat[1]),
        .q   (store)
    );

    for (genvar r = 0; r < N_RD; r++) begin : g_rd
        rf_read_port #(.DW(DW), .DEPTH(N_PHYS)) u_rp (
            .num_i  (rnum[r]),
            .bank_i (bank),
            .store_i(store),
            .pc_i   (pc_in),
            .data_o (rdat[r])
        );
    end

    always_comb begin
        pc_write = |wpc;
        pc_wdata = '0;
        if (wpc[1])      pc_wdata = wdat[1];
        else if (wpc[0]) pc_wdata = wdat[0];
    end
endmodule

// File: rtl/rf_checker.sv
module rf_checker (
    input logic        clk,
    input logic        rst,
    input logic [4:0]  mode_i,
    input logic [31:0] pc_in,
    input logic [3:0]  rd0_addr,
    input logic [31:0] rd0_data,
    input logic        wr0_en,
    input logic [3:0]  wr0_addr,
    input logic [31:0] wr0_data,
    input logic        wr1_en,
    input logic [3:0]  wr1_addr,
    input logic [31:0] wr1_data,
    input logic        pc_write,
    input logic [31:0] pc_wdata
);
    a_r7_pc_read: assert property (@(posedge clk) disable iff (rst)
        (rd0_addr == 4'd15) |-> (rd0_data == pc_in));

    a_r8_pc_strobe: assert property (@(posedge clk) disable iff (rst)
        (wr0_en && wr0_addr == 4'd15 && !(wr1_en && wr1_addr == 4'd15))
            |-> (pc_write && pc_wdata == wr0_data));

    a_r8_no_strobe: assert property (@(posedge clk) disable iff (rst)
        !((wr0_en && wr0_addr == 4'd15) || (wr1_en && wr1_addr == 4'd15)) |-> !pc_write);

    a_r9_pc_conflict: assert property (@(posedge clk) disable iff (rst)
        (wr1_en && wr1_addr == 4'd15) |-> (pc_write && pc_wdata == wr1_data));

    // R2 and R9: port 1's data is what a same-mode read sees after the edge
    a_r2_port1_lands: assert property (@(posedge clk) disable iff (rst)
        (wr1_en && wr1_addr != 4'd15) |=>
            (rd0_addr != $past(wr1_addr) || mode_i != $past(mode_i)
             || rd0_data == $past(wr1_data)));

    a_r3_unbanked_stable: assert property (@(posedge clk) disable iff (rst)
        (rd0_addr < 4'd8 && $stable(rd0_addr) && $past(!rst)
         && $past(!wr0_en && !wr1_en)) |-> $stable(rd0_data));

    a_r10_reset_clear: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && rd0_addr != 4'd15) |-> (rd0_data == 32'd0));
endmodule

bind banked_regfile rf_checker u_chk (
    .clk(clk), .rst(rst), .mode_i(mode_i), .pc_in(pc_in),
    .rd0_addr(rd0_addr), .rd0_data(rd0_data),
    .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
    .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data),
    .pc_write(pc_write), .pc_wdata(pc_wdata)
);

// File: tb/tb_banked_regfile.sv
module tb_banked_regfile;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  mode_i = 5'h10;
    logic [31:0] pc_in = 32'h0;
    logic [3:0]  rd0_addr = 0, rd1_addr = 0, rd2_addr = 0;
    logic [31:0] rd0_data, rd1_data, rd2_data;
    logic        wr0_en = 0, wr1_en = 0;
    logic [3:0]  wr0_addr = 0, wr1_addr = 0;
    logic [31:0] wr0_data = 0, wr1_data = 0;
    logic        pc_write;
    logic [31:0] pc_wdata;

    int n_checks = 0;
    int n_fail   = 0;
    logic [31:0] model [30];

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_regfile dut (
        .clk(clk), .rst(rst), .mode_i(mode_i), .pc_in(pc_in),
        .rd0_addr(rd0_addr), .rd0_data(rd0_data),
        .rd1_addr(rd1_addr), .rd1_data(rd1_data),
        .rd2_addr(rd2_addr), .rd2_data(rd2_data),
        .wr0_en(wr0_en), .wr0_addr(wr0_addr), .wr0_data(wr0_data),
        .wr1_en(wr1_en), .wr1_addr(wr1_addr), .wr1_data(wr1_data),
        .pc_write(pc_write), .pc_wdata(pc_wdata)
    );

    // Bench-side slot numbering: 0..14 user view, 15..21 fast R8..R14,
    // 22/23 irq, 24/25 svc, 26/27 abort, 28/29 undef.
    function automatic int slot_of(input logic [4:0] m, input logic [3:0] a);
        int base;
        if (a < 4'd8) return int'(a);
        if (m == 5'h11) return 15 + int'(a) - 8;
        if (a < 4'd13) return int'(a);
        case (m)
            5'h12:   base = 22;
            5'h13:   base = 24;
            5'h17:   base = 26;
            5'h1B:   base = 28;
            default: base = 13;
        endcase
        return base + int'(a) - 13;
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        if (a == 4'd15) return "R7";
        if (a < 4'd8)   return "R3";
        if (a < 4'd13)  return "R4";
        return "R5";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [3:0] a);
        if (a == 4'd15) return pc_in;
        return model[slot_of(mode_i, a)];
    endfunction

    // R1: combinational reads compared against the model before the edge
    task automatic check_now();
        logic        e_pcw;
        logic [31:0] e_pcd;
        chk(tag_of(rd0_addr), rd0_data, exp_read(rd0_addr));
        chk(tag_of(rd1_addr), rd1_data, exp_read(rd1_addr));
        chk(tag_of(rd2_addr), rd2_data, exp_read(rd2_addr));
        e_pcw = (wr0_en && wr0_addr == 4'd15) || (wr1_en && wr1_addr == 4'd15);
        e_pcd = (wr1_en && wr1_addr == 4'd15) ? wr1_data : wr0_data;
        chk("R8", {31'd0, pc_write}, {31'd0, e_pcw});
        if (e_pcw) chk("R9", pc_wdata, e_pcd);
    endtask

    task automatic step();
        #1;
        if (!rst) check_now();
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < 30; i++) model[i] = '0;
        end else begin
            if (wr0_en && wr0_addr != 4'd15) model[slot_of(mode_i, wr0_addr)] = wr0_data;
            if (wr1_en && wr1_addr != 4'd15) model[slot_of(mode_i, wr1_addr)] = wr1_data;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        wr0_en = 0; wr1_en = 0;
    endtask

    task automatic check_all_zero(input string tag);
        for (int a = 0; a < 15; a++) begin
            rd0_addr = 4'(a);
            #1;
            chk(tag, rd0_data, 32'd0);
        end
    endtask

    logic [4:0] modes [8] = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B, 5'h1F, 5'h05};

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20251));
        for (int i = 0; i < 30; i++) model[i] = '0;
        @(negedge clk); step(); step();
        rst = 0;
        // R10: every stored register reads zero after reset
        mode_i = 5'h10; check_all_zero("R10");
        mode_i = 5'h11; check_all_zero("R10");

        // R2: write then read back after the edge
        mode_i = 5'h10; wr0_en = 1; wr0_addr = 4'd3; wr0_data = 32'hA5A5_0003;
        rd0_addr = 4'd3; #1; chk("R1", rd0_data, 32'd0);
        step(); idle(); #1; chk("R2", rd0_data, 32'hA5A5_0003);

        // R4: fast-interrupt R10 separate from shared R10
        wr0_en = 1; wr0_addr = 4'd10; wr0_data = 32'h0000_1010; step();
        mode_i = 5'h11; wr0_data = 32'h0000_F010; step(); idle();
        rd1_addr = 4'd10; #1; chk("R4", rd1_data, 32'h0000_F010);
        mode_i = 5'h13; #1; chk("R4", rd1_data, 32'h0000_1010);

        // R5/R6: illegal mode shares user R13, system too; irq separate
        mode_i = 5'h00; wr0_en = 1; wr0_addr = 4'd13; wr0_data = 32'h0000_5555; step();
        mode_i = 5'h12; wr0_data = 32'h0000_1212; step(); idle();
        rd2_addr = 4'd13; mode_i = 5'h10; #1; chk("R6", rd2_data, 32'h0000_5555);
        mode_i = 5'h1F; #1; chk("R5", rd2_data, 32'h0000_5555);
        mode_i = 5'h12; #1; chk("R5", rd2_data, 32'h0000_1212);

        // R9: both ports on supervisor R14
        mode_i = 5'h13; wr0_en = 1; wr1_en = 1;
        wr0_addr = 4'd14; wr1_addr = 4'd14; wr0_data = 32'h0000_000A; wr1_data = 32'h0000_000B;
        step(); idle(); rd0_addr = 4'd14; #1; chk("R9", rd0_data, 32'h0000_000B);

        // R7/R8/R9: PC traffic, storage untouched
        pc_in = 32'h0000_8000; rd0_addr = 4'd15; #1; chk("R7", rd0_data, 32'h0000_8000);
        wr0_en = 1; wr1_en = 1; wr0_addr = 4'd15; wr1_addr = 4'd15;
        wr0_data = 32'h1111_0000; wr1_data = 32'h2222_0000;
        #1; chk("R8", {31'd0, pc_write}, 32'd1); chk("R9", pc_wdata, 32'h2222_0000);
        step(); idle();
        for (int a = 0; a < 15; a++) begin
            rd0_addr = 4'(a); #1; chk("R8", rd0_data, exp_read(4'(a)));
        end

        // Random traffic
        for (int c = 0; c < 4000; c++) begin
            mode_i   = modes[$urandom_range(7, 0)];
            pc_in    = $urandom;
            rd0_addr = 4'($urandom); rd1_addr = 4'($urandom); rd2_addr = 4'($urandom);
            wr0_en   = 1'($urandom); wr1_en = 1'($urandom);
            wr0_addr = 4'($urandom); wr0_data = $urandom;
            wr1_addr = ($urandom_range(3, 0) == 0) ? wr0_addr : 4'($urandom);
            wr1_data = $urandom;
            if (c == 2000) begin
                rst = 1; step(); rst = 0; idle();
                mode_i = 5'h1B; check_all_zero("R10");
            end else begin
                step();
            end
        end

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule